// File: doc/BRIEF.md
# Single-Slot Pass-Through Queue

This block is a queue of depth one that lets a producer and a consumer meet in the same clock cycle. It holds a single data word and a flag that says whether the word is present. When the slot is empty, a word offered by the producer appears at the consumer side at once and can be taken in that same cycle. In that case the word never lands in the register, so the queue adds no latency. When the consumer does not take the word, it is kept until it is removed.

Within one cycle the operations act in a fixed logical order. An insert comes first, then the read of the head, then the removal, and a flush has the last word. The consumer's ready signal therefore depends on the producer's request in the same cycle, and there is a combinational path between the two ports. The data width is a parameter.

Top module: `bfifo1_bypass`

## Requirements
- R1: After reset the slot is empty: with no requests, `enq_ready` is 1 and `deq_ready` is 0.
- R2: `enq_ready` is 0 exactly while the slot holds a word.
- R3: While the slot is empty and `enq_en` is 1, in the same cycle `deq_ready` is 1 and `first_data` equals `enq_data`.
- R4: An insert and a removal together on an empty slot leave it empty at the next cycle.
- R5: An insert without a removal or flush on an empty slot fills it: from the next cycle `enq_ready` is 0 and `first_data` shows the inserted word.
- R6: A removal from a full slot without a flush leaves it empty at the next cycle, whatever `enq_en` is.
- R7: A flush (`clear` = 1) leaves the slot empty at the next cycle, whatever the other requests are.
- R8: An insert request while full has no effect: the held word is unchanged.
- R9: A removal request on an empty slot with no insert is not accepted (`deq_ready` = 0) and changes nothing.
- R10: While full with no removal and no flush, `first_data` stays stable whatever `enq_data` is.
- R11: A removal from a full slot does not make room for an insert in the same cycle: `enq_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_en | input | 1 | Producer offers a word |
| enq_data | input | W | Word offered |
| enq_ready | output | 1 | Slot can take a word this cycle |
| deq_en | input | 1 | Consumer takes the head word |
| deq_ready | output | 1 | A head word is available this cycle |
| first_data | output | W | Head word (stored or passed through) |
| clear | input | 1 | Flush; acts after insert and removal |

## Verification
The checker watches, on every cycle, the same-cycle pass-through (R3), the link between the two ready signals, and the next-cycle occupancy after each kind of request, flush included. It also checks that the head word stays stable while the slot is held. Only the directed scenarios show that a refused insert leaves the stored word as it was. They also show that a refused removal on an empty slot does not disturb a later fill, and that the ready outputs read correctly at known points in a sequence.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

  // Occupancy of the single slot.
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_HELD  = 1'b1
  } slot_e;

  // Default data width for the queue.
  localparam int unsigned BF_DEF_W = 8;

endpackage

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
  import bfifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enq_en,
  input  logic deq_en,
  input  logic clear,
  output logic held,
  output logic enq_ready,
  output logic deq_ready,
  output logic enq_fire,
  output logic deq_fire
);

  slot_e state_q;
  slot_e state_d;

  // Request qualification, in logical order: insert, then removal.
  always_comb begin
    held      = (state_q == SLOT_HELD);
    enq_ready = !held;
    enq_fire  = enq_en && enq_ready;
    deq_ready = held || enq_fire;
    deq_fire  = deq_en && deq_ready;
  end

  // Next occupancy; a flush is applied last.
  always_comb begin
    state_d = state_q;
    if (held) begin
      if (deq_fire) state_d = SLOT_EMPTY;
    end else begin
      if (enq_fire && !deq_fire) state_d = SLOT_HELD;
    end
    if (clear) state_d = SLOT_EMPTY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_EMPTY;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/bfifo_store.sv
module bfifo_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] data_q;
  logic [W-1:0] data_d;

  // Clock enable written out: hold unless loading.
  always_comb begin
    data_d = data_q;
    if (load) data_d = din;
  end

  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

  assign dout = data_q;

endmodule

// File: rtl/bfifo_head_mux.sv
module bfifo_head_mux #(
  parameter int unsigned W = 8
) (
  input  logic         use_stored,
  input  logic [W-1:0] stored,
  input  logic [W-1:0] incoming,
  output logic [W-1:0] head
);

  always_comb begin
    if (use_stored) head = stored;
    else            head = incoming;
  end

endmodule

// File: rtl/bfifo1_bypass.sv
module bfifo1_bypass #(
  parameter int unsigned W = bfifo_pkg::BF_DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq_en,
  input  logic [W-1:0] enq_data,
  output logic         enq_ready,
  input  logic         deq_en,
  output logic         deq_ready,
  output logic [W-1:0] first_data,
  input  logic         clear
);

  logic         held;
  logic         enq_fire;
  logic         deq_fire;
  logic         load;
  logic [W-1:0] stored;

  bfifo_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_en    (enq_en),
    .deq_en    (deq_en),
    .clear     (clear),
    .held      (held),
    .enq_ready (enq_ready),
    .deq_ready (deq_ready),
    .enq_fire  (enq_fire),
    .deq_fire  (deq_fire)
  );

  // Only a word that is not consumed in passing is written.
  assign load = enq_fire && !deq_fire;

  bfifo_store #(.W(W)) u_store (
    .clk  (clk),
    .load (load),
    .din  (enq_data),
    .dout (stored)
  );

  bfifo_head_mux #(.W(W)) u_mux (
    .use_stored (held),
    .stored     (stored),
    .incoming   (enq_data),
    .head       (first_data)
  );

endmodule

// File: rtl/bfifo1_bypass_chk.sv
module bfifo1_bypass_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enq_en,
  input logic [W-1:0] enq_data,
  input logic         enq_ready,
  input logic         deq_en,
  input logic         deq_ready,
  input logic [W-1:0] first_data,
  input logic         clear
);

  // R2
  full_offers_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enq_ready |-> deq_ready);

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_ready && enq_en) |-> (deq_ready && first_data == enq_data));

  // R9
  empty_no_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_ready && !enq_en) |-> !deq_ready);

  // R4
  pass_stays_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_ready && enq_en && deq_en) |=> enq_ready);

  // R5
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_ready && enq_en && !deq_en && !clear) |=>
      (!enq_ready && first_data == $past(enq_data)));

  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_ready && deq_en) |=> enq_ready);

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> enq_ready);

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_ready && !deq_en && !clear) |=> (!enq_ready && $stable(first_data)));

endmodule

bind bfifo1_bypass bfifo1_bypass_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enq_en     (enq_en),
  .enq_data   (enq_data),
  .enq_ready  (enq_ready),
  .deq_en     (deq_en),
  .deq_ready  (deq_ready),
  .first_data (first_data),
  .clear      (clear)
);

// File: tb/tb_bfifo1_bypass.sv
module tb_bfifo1_bypass;

  localparam int unsigned W = 8;

  logic         clk;
  logic         rst_n;
  logic         enq_en;
  logic [W-1:0] enq_data;
  logic         enq_ready;
  logic         deq_en;
  logic         deq_ready;
  logic [W-1:0] first_data;
  logic         clear;

  int n_chk;
  int n_bad;

  bfifo1_bypass #(.W(W)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_en     (enq_en),
    .enq_data   (enq_data),
    .enq_ready  (enq_ready),
    .deq_en     (deq_en),
    .deq_ready  (deq_ready),
    .first_data (first_data),
    .clear      (clear)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, let logic settle before sampling.
  task automatic drive(input logic e, input logic [W-1:0] d, input logic q, input logic c);
    @(negedge clk);
    enq_en = e; enq_data = d; deq_en = q; clear = c;
    #1;
  endtask

  task automatic idle(input logic [W-1:0] d);
    drive(1'b0, d, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    idle(8'h00);
    check("R1 enq_ready", {7'd0, enq_ready}, 8'd1);
    check("R1 deq_ready", {7'd0, deq_ready}, 8'd0);
  endtask

  task automatic t_bypass();
    drive(1'b1, 8'hA5, 1'b1, 1'b0);
    check("R3 deq_ready", {7'd0, deq_ready}, 8'd1);
    check("R3 first_data", first_data, 8'hA5);
    idle(8'h11);
    check("R4 empty enq_ready", {7'd0, enq_ready}, 8'd1);
    check("R4 empty deq_ready", {7'd0, deq_ready}, 8'd0);
  endtask

  task automatic t_fill();
    drive(1'b1, 8'h3C, 1'b0, 1'b0);
    idle(8'hFF);
    check("R2 enq_ready full", {7'd0, enq_ready}, 8'd0);
    check("R5 deq_ready", {7'd0, deq_ready}, 8'd1);
    check("R5 first_data", first_data, 8'h3C);
    idle(8'h00);
    check("R10 first_data stable", first_data, 8'h3C);
  endtask

  task automatic t_enq_when_full();
    drive(1'b1, 8'h77, 1'b0, 1'b0);
    check("R2 enq_ready", {7'd0, enq_ready}, 8'd0);
    check("R10 head with new enq_data", first_data, 8'h3C);
    idle(8'h00);
    check("R8 held word", first_data, 8'h3C);
  endtask

  task automatic t_drain_with_enq();
    drive(1'b1, 8'h55, 1'b1, 1'b0);
    check("R11 enq_ready", {7'd0, enq_ready}, 8'd0);
    check("R6 head", first_data, 8'h3C);
    idle(8'h00);
    check("R6 enq_ready", {7'd0, enq_ready}, 8'd1);
    check("R6 deq_ready", {7'd0, deq_ready}, 8'd0);
  endtask

  task automatic t_empty_deq();
    drive(1'b0, 8'h99, 1'b1, 1'b0);
    check("R9 deq_ready", {7'd0, deq_ready}, 8'd0);
    idle(8'h00);
    check("R9 still empty", {7'd0, enq_ready}, 8'd1);
    drive(1'b1, 8'h12, 1'b0, 1'b0);
    idle(8'h00);
    check("R9 later fill", first_data, 8'h12);
    check("R9 later fill full", {7'd0, enq_ready}, 8'd0);
  endtask

  task automatic t_clear();
    // Full slot (holds 12), flush.
    drive(1'b0, 8'h00, 1'b0, 1'b1);
    idle(8'h00);
    check("R7 flush full", {7'd0, enq_ready}, 8'd1);
    check("R7 flush full deq_ready", {7'd0, deq_ready}, 8'd0);
    // Insert and flush together on empty.
    drive(1'b1, 8'h44, 1'b0, 1'b1);
    idle(8'h00);
    check("R7 flush over insert", {7'd0, enq_ready}, 8'd1);
    // Fill, then removal with flush.
    drive(1'b1, 8'h66, 1'b0, 1'b0);
    drive(1'b0, 8'h00, 1'b1, 1'b1);
    idle(8'h00);
    check("R7 flush with removal", {7'd0, enq_ready}, 8'd1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; enq_en = 1'b0; enq_data = '0; deq_en = 1'b0; clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_fill();
    t_enq_when_full();
    t_drain_with_enq();
    t_empty_deq();
    t_clear();
    idle(8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule